// File: doc/BRIEF.md
# Page-Draining Circular Log Buffer

This block sits between a logging source that delivers one byte per clock and a storage writer that accepts data only in whole pages. Incoming bytes are appended at the head of a circular store that holds several pages. The writer at the tail is offered nothing until an entire page has arrived, and then receives that page as one burst of exactly one page's worth of beats under valid/ready handshaking, with the final beat marked. Because the store spans many pages, long pauses on the storage side are absorbed. Bytes are lost only when the writer's average rate over the whole buffer falls below the producer's rate. In that case the store is full, further bytes are discarded, a sticky overflow flag is set and a saturating counter records the number of lost bytes.

A second control path counts pages that have been fully handed to the writer. After a programmable number of them it raises a flush request, which tells the storage side to commit what it has so that a power loss costs only recent data. The request stays up until acknowledged, and the page count then starts again from zero. The page size and page count are parameters (the page is 512 bytes by default; a capacity of around a hundred pages suits storage with long write pauses). Both must be powers of two.

The drain controller has two states. DR_IDLE moves to DR_BURST ("start") when at least one full page is pending. DR_BURST stays in DR_BURST ("chain") on the last-beat handshake if another full page is pending, and returns to DR_IDLE ("finish") on the last-beat handshake otherwise. The flush controller also has two states. FL_COUNT moves to FL_HOLD ("trip") when a page completes and the count reaches the threshold. FL_HOLD returns to FL_COUNT ("release") on acknowledge.

Top module: `logpage_buf`

## Requirements
- R1: After reset, out_valid, page_avail, flush_req and overflow are 0, and pages_pending and drop_count are 0.
- R2: A page is offered only once all PAGE_BYTES of its bytes are stored. page_avail and pages_pending rise on the clock edge that stores a page's final byte. out_valid rises one clock later.
- R3: A burst is exactly PAGE_BYTES handshaken beats, with data in arrival order and out_last high on the final beat only. While out_valid is high and out_ready low, out_valid, out_data and out_last hold.
- R4: If another full page is pending when a page's last beat is taken, out_valid stays high on the following cycle with no idle gap.
- R5: pages_pending equals the number of full pages stored whose last beat has not yet been taken. It never exceeds NUM_PAGES.
- R6: The store holds NUM_PAGES*PAGE_BYTES bytes. A byte presented while the store is full is discarded, leaving the stored data unchanged. Each discarded byte sets overflow, which stays set until reset, and adds one to drop_count, which saturates at its all-ones value.
- R7: flush_req rises on the edge that completes the flush_every-th page since the last acknowledge. It then holds until flush_ack is sampled high and clears on that edge. Pages completed while it is held are not counted. flush_every of 0 never raises a request.
- R8: Data order is preserved across wrap-around of the circular store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is presented this cycle |
| in_data | input | 8 | Incoming log byte |
| out_ready | input | 1 | Writer accepts the current beat |
| out_valid | output | 1 | A beat of a full page is offered |
| out_data | output | 8 | Beat data |
| out_last | output | 1 | Final beat of the page |
| page_avail | output | 1 | At least one full page is pending |
| pages_pending | output | $clog2(NUM_PAGES+1) | Full pages not yet completely drained |
| flush_every | input | CW | Pages between flush requests, 0 disables |
| flush_req | output | 1 | Flush request, held until acknowledged |
| flush_ack | input | 1 | Acknowledge of the flush request |
| overflow | output | 1 | Sticky: a byte was discarded |
| drop_count | output | DROP_W | Saturating count of discarded bytes |

## Verification
On every cycle, assertions check the following: that a burst is never offered without a full page pending, that a stalled beat holds its data and marker, that the pending count stays within capacity, that overflow is sticky and is set by a byte arriving while full, and that the flush request holds until acknowledged and rises only on a completed page. Only the bench's scenarios can show the byte-exact order of data through fill, overflow and wrap-around. The same is true of the exact cycle at which a page becomes visible, the back-to-back chaining of pages, saturation of the drop count, and the flush count restarting from zero after an acknowledge across several thresholds and ready patterns.

// File: rtl/lb_pkg.sv
package lb_pkg;
    typedef enum logic {DR_IDLE, DR_BURST} drain_st_t;
    typedef enum logic {FL_COUNT, FL_HOLD} flush_st_t;
endpackage

// File: rtl/lb_store.sv
module lb_store #(
    parameter int DEPTH = 2048,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/lb_drain.sv
module lb_drain import lb_pkg::*; #(
    parameter int PAGE_BYTES = 512,
    parameter int NUM_PAGES  = 4,
    localparam int DEPTH     = PAGE_BYTES * NUM_PAGES,
    localparam int AW        = $clog2(DEPTH),
    localparam int OW        = $clog2(PAGE_BYTES),
    localparam int PW        = $clog2(NUM_PAGES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pages_ready,
    input  logic          out_ready,
    output logic          out_valid,
    output logic          out_last,
    output logic [AW-1:0] rd_addr,
    output logic          page_done
);
    drain_st_t state, state_nxt;
    logic [AW-1:0] rd_ptr;
    logic          end_of_page;

    assign end_of_page = (rd_ptr[OW-1:0] == {OW{1'b1}});
    assign rd_addr     = rd_ptr;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= DR_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            DR_IDLE:  if (pages_ready != '0) state_nxt = DR_BURST;
            DR_BURST: if (out_ready && end_of_page)
                          state_nxt = (pages_ready > PW'(1)) ? DR_BURST : DR_IDLE;
        endcase
    end

    always_comb begin
        out_valid = 1'b0;
        unique case (state)
            DR_IDLE:  out_valid = 1'b0;
            DR_BURST: out_valid = 1'b1;
        endcase
        out_last  = out_valid && end_of_page;
        page_done = out_valid && out_ready && end_of_page;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                      rd_ptr <= '0;
        else if (out_valid && out_ready) rd_ptr <= rd_ptr + AW'(1);
    end

    // R2: a burst is never offered unless a full page is pending
    p_offer_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (pages_ready != '0));
    // R3: after the last beat the read pointer sits at a page boundary
    p_page_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |=> (rd_ptr[OW-1:0] == '0));
endmodule

// File: rtl/lb_flush.sv
module lb_flush import lb_pkg::*; #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          page_done,
    input  logic          flush_ack,
    input  logic [CW-1:0] flush_every,
    output logic          flush_req
);
    flush_st_t state, state_nxt;
    logic [CW-1:0] pg_cnt;
    logic          trip;

    assign trip = page_done && (flush_every != '0) && ((pg_cnt + CW'(1)) >= flush_every);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= FL_COUNT;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            FL_COUNT: if (trip)      state_nxt = FL_HOLD;
            FL_HOLD:  if (flush_ack) state_nxt = FL_COUNT;
        endcase
    end

    always_comb begin
        flush_req = 1'b0;
        unique case (state)
            FL_COUNT: flush_req = 1'b0;
            FL_HOLD:  flush_req = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pg_cnt <= '0;
        else if (state == FL_COUNT && page_done && flush_every != '0)
            pg_cnt <= trip ? '0 : pg_cnt + CW'(1);
    end

    // R7: request holds until acknowledged
    p_flush_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_ack) |=> flush_req);
    // R7: acknowledge clears the request
    p_flush_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && flush_ack) |=> !flush_req);
    // R7: a request only appears after a completed page
    p_flush_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_req) |-> $past(page_done));
endmodule

// File: rtl/logpage_buf.sv
module logpage_buf import lb_pkg::*; #(
    parameter int PAGE_BYTES = 512,
    parameter int NUM_PAGES  = 4,
    parameter int CW         = 8,
    parameter int DROP_W     = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [7:0]                     in_data,
    input  logic                           out_ready,
    output logic                           out_valid,
    output logic [7:0]                     out_data,
    output logic                           out_last,
    output logic                           page_avail,
    output logic [$clog2(NUM_PAGES+1)-1:0] pages_pending,
    input  logic [CW-1:0]                  flush_every,
    output logic                           flush_req,
    input  logic                           flush_ack,
    output logic                           overflow,
    output logic [DROP_W-1:0]              drop_count
);
    localparam int DEPTH = PAGE_BYTES * NUM_PAGES;
    localparam int AW    = $clog2(DEPTH);
    localparam int OW    = $clog2(PAGE_BYTES);
    localparam int BW    = $clog2(DEPTH + 1);
    localparam int PW    = $clog2(NUM_PAGES + 1);

    logic [AW-1:0] wr_ptr, rd_addr;
    logic [BW-1:0] byte_cnt;
    logic [PW-1:0] page_cnt;
    logic          full, accept, beat, page_fill, page_done;

    assign full      = (byte_cnt == BW'(DEPTH));
    assign accept    = in_valid && !full;
    assign beat      = out_valid && out_ready;
    assign page_fill = accept && (wr_ptr[OW-1:0] == {OW{1'b1}});

    lb_store #(.DEPTH(DEPTH), .DW(8)) store_i (
        .clk(clk), .we(accept), .waddr(wr_ptr), .wdata(in_data),
        .raddr(rd_addr), .rdata(out_data)
    );

    lb_drain #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)) drain_i (
        .clk(clk), .rst_n(rst_n), .pages_ready(page_cnt), .out_ready(out_ready),
        .out_valid(out_valid), .out_last(out_last), .rd_addr(rd_addr),
        .page_done(page_done)
    );

    lb_flush #(.CW(CW)) flush_i (
        .clk(clk), .rst_n(rst_n), .page_done(page_done), .flush_ack(flush_ack),
        .flush_every(flush_every), .flush_req(flush_req)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            byte_cnt <= '0;
            page_cnt <= '0;
        end else begin
            if (accept) wr_ptr <= wr_ptr + AW'(1);
            byte_cnt <= byte_cnt + BW'(accept) - BW'(beat);
            page_cnt <= page_cnt + PW'(page_fill) - PW'(page_done);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow   <= 1'b0;
            drop_count <= '0;
        end else if (in_valid && full) begin
            overflow <= 1'b1;
            if (drop_count != {DROP_W{1'b1}}) drop_count <= drop_count + DROP_W'(1);
        end
    end

    assign page_avail    = (page_cnt != '0);
    assign pages_pending = page_cnt;

    // R3: a stalled beat holds valid, data and marker
    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
    // R5: pending pages never exceed capacity
    p_pending_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pages_pending <= PW'(NUM_PAGES));
    // R6: a byte arriving while full sets overflow
    p_drop_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && full) |=> overflow);
    // R6: overflow is sticky
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: tb/logpage_buf_tb.sv
`timescale 1ns/1ps
module logpage_buf_tb_top;
    localparam int PB = 8;
    localparam int NP = 4;
    localparam int DEPTH = PB * NP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic out_ready = 1'b0;
    logic out_valid, out_last, page_avail, flush_req, overflow;
    logic [7:0] out_data;
    logic [2:0] pages_pending;
    logic [3:0] flush_every = 4'd2;
    logic flush_ack = 1'b0;
    logic [2:0] drop_count;

    int n_tests = 0;
    int n_fail = 0;
    logic [7:0] q[$];
    int mbytes = 0, mpages = 0, waccepted = 0;
    int fcnt = 0;
    bit fexp = 0;
    logic [7:0] gen = 8'h30;
    int drops = 0;

    always #2.5 clk = ~clk;

    logpage_buf #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .CW(4), .DROP_W(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .page_avail(page_avail), .pages_pending(pages_pending),
        .flush_every(flush_every), .flush_req(flush_req), .flush_ack(flush_ack),
        .overflow(overflow), .drop_count(drop_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = gen;
            if (mbytes < DEPTH) begin
                q.push_back(gen);
                mbytes++;
                if (waccepted % PB == PB - 1) mpages++;
                waccepted++;
            end else begin
                drops++;
            end
            gen++;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain_page(input int pat);
        int beats = 0;
        int cyc = 0;
        bit holding = 0;
        logic [7:0] hd = '0;
        logic hl = 1'b0;
        bit rdy;
        while (beats < PB) begin
            @(negedge clk);
            if (holding) begin
                chk(out_valid == 1'b1, "R3 stall valid", out_valid, 1);
                chk(out_data == hd, "R3 stall data", out_data, hd);
                chk(out_last == hl, "R3 stall last", out_last, hl);
                holding = 0;
            end
            rdy = (pat == 0) || ((cyc % (pat + 1)) == pat);
            out_ready = rdy;
            if (out_valid && rdy) begin
                chk(out_data == q[0], "R3/R8 data order", out_data, q[0]);
                chk(out_last == (beats == PB - 1), "R3 last marker", out_last, beats == PB - 1);
                void'(q.pop_front());
                mbytes--;
                beats++;
            end else if (out_valid) begin
                holding = 1;
                hd = out_data;
                hl = out_last;
            end
            cyc++;
        end
        mpages--;
        if (!fexp && flush_every != 0) begin
            if (fcnt + 1 >= flush_every) begin fexp = 1; fcnt = 0; end
            else fcnt++;
        end
        @(negedge clk);
        out_ready = 1'b0;
        chk(out_valid == (mpages > 0), "R4 chaining", out_valid, mpages > 0);
        chk(pages_pending == mpages, "R5 pending after drain", pages_pending, mpages);
        chk(flush_req == fexp, "R7 flush after page", flush_req, fexp);
    endtask

    task automatic ack();
        @(negedge clk);
        flush_ack = 1'b1;
        @(negedge clk);
        flush_ack = 1'b0;
        fexp = 0;
        fcnt = 0;
        chk(flush_req == 1'b0, "R7 ack clears", flush_req, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);
        chk(page_avail == 0, "R1 page_avail", page_avail, 0);
        chk(flush_req == 0, "R1 flush_req", flush_req, 0);
        chk(overflow == 0, "R1 overflow", overflow, 0);
        chk(pages_pending == 0, "R1 pages_pending", pages_pending, 0);
        chk(drop_count == 0, "R1 drop_count", drop_count, 0);

        // R2 partial page is not offered
        push(PB - 1);
        chk(page_avail == 0, "R2 partial page", page_avail, 0);
        repeat (3) @(negedge clk);
        chk(out_valid == 0, "R2 no burst on partial", out_valid, 0);
        push(1);
        chk(page_avail == 1, "R2 page visible", page_avail, 1);
        chk(pages_pending == 1, "R2 pending one", pages_pending, 1);
        chk(out_valid == 0, "R2 offer one cycle later", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1, "R2 offer", out_valid, 1);

        // R5/R6 fill to capacity and overflow
        push(3 * PB);
        chk(pages_pending == NP, "R5 full count", pages_pending, NP);
        push(10);
        chk(overflow == 1, "R6 overflow set", overflow, 1);
        chk(drop_count == 3'd7, "R6 drop saturates", drop_count, 7);
        chk(drops == 10, "R6 bench drop count", drops, 10);
        chk(pages_pending == NP, "R6 stored unchanged", pages_pending, NP);

        // R3/R4/R7 drain with stalls, flush every 2
        drain_page(0);
        drain_page(1);
        repeat (5) @(negedge clk);
        chk(flush_req == 1, "R7 held", flush_req, 1);
        drain_page(2);
        drain_page(3);
        chk(page_avail == 0, "R5 empty", page_avail, 0);
        chk(overflow == 1, "R6 overflow sticky", overflow, 1);
        ack();

        // R8 wrap-around, R7 counting restarts from zero
        push(2 * PB);
        drain_page(1);
        drain_page(0);
        ack();

        // R7 disabled with zero threshold
        flush_every = 4'd0;
        push(PB);
        drain_page(2);
        repeat (3) @(negedge clk);
        chk(flush_req == 0, "R7 disabled", flush_req, 0);

        // near-exhaustive sweep over thresholds and ready patterns
        for (int fe = 1; fe <= 3; fe++) begin
            flush_every = 4'(fe);
            fcnt = 0;
            for (int it = 0; it < 4; it++) begin
                push((it % 2 + 1) * PB);
                for (int p = 0; p <= it % 2; p++) begin
                    drain_page((it + p + fe) % 4);
                    if (fexp) ack();
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule